// File: doc/BRIEF.md
# Output Clock Stop and Power-Down Sequencer

This block sits between a bank of generated clocks and their output drivers. Each output passes through its own glitch-free gate, and a sequencer on the reference clock decides which gates open. It also decides whether each driver is active or in tristate. A single level-sensitive pin does two jobs. It starts high. When it first goes low, the block captures the frequency-select and debug-port straps and begins a start-up wait. From then on the pin is a live power-down request: high means power down, low means run.

When power-down is requested, every gate is closed and confirmed low before the block raises the VCO shutdown request. When power-down is released, the shutdown request drops and the drivers come back at once. The gates stay closed until a stabilization counter on the reference clock expires. A software stop input freezes the stoppable outputs, and per-output free-run, output-enable and drive-mode bits refine this.

Outputs are grouped by position. The CPU outputs come first, then SRC, PCI, PCIF and finally the always-running auxiliary outputs.

Top module: `clkstop_seq`

## Requirements
- R1: While `por_n` is low, and while the pin has not yet gone low since reset, every `gclk` stays low and `vco_off` is 1. During reset, `drive_en` is 0 and `fs_lat`/`itp_lat` are 0.
- R2: The first low level of `pg_pd` after reset captures `fs_strap` and `itp_strap` into `fs_lat`/`itp_lat`. Later strap changes and later power-down cycles leave the captured values unchanged.
- R3: After the pin goes low (first time, or on power-down release), `vco_off` drops and all gates stay closed for `STAB_CYCLES` reference cycles. After that, the enabled outputs run.
- R4: With `sw_stop_n` = 0, the SRC, PCI and PCIF outputs stop. CPU (bits 0..NCPU-1) and auxiliary (top NAUX bits) outputs keep running.
- R5: An SRC output whose `src_freerun` bit is 1, or a PCIF output whose `pcif_freerun` bit is 1, ignores the software stop. PCI outputs have no such exemption.
- R6: An output whose `oe` bit is 0 has `drive_en` 0 and its gate closed.
- R7: While the pin is high after capture, all gates close. `vco_off` rises only when every `gclk` is already low.
- R8: While `vco_off` is 1, a differential output (CPU bits, then SRC bits; `diff_pdtri` bit k belongs to output k) has `drive_en` 0 if its `diff_pdtri` bit is 1. Otherwise it is driven low. Single-ended outputs stay driven.
- R9: An SRC output stopped by the software stop has `drive_en` 0 when `src_stop_tri` is 1. It is driven low when `src_stop_tri` is 0.
- R10: Every high pulse on a `gclk` bit lasts a full half-period of its source clock. No runt pulse appears on opening or closing.
- R11: On power-down release, `drive_en` returns to its run value within a few reference cycles, while the gates are still closed for stabilization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for the sequencer |
| por_n | input | 1 | Active-low power-on reset |
| pg_pd | input | 1 | Low: power good / run; high before capture: not ready; high after capture: power down |
| gen_clk | input | N | Generated clocks, ordered CPU, SRC, PCI, PCIF, AUX |
| fs_strap | input | FSW | Frequency-select strap pins |
| itp_strap | input | 1 | Debug-port select strap pin |
| sw_stop_n | input | 1 | Software stop, active low |
| src_freerun | input | NSRC | 1: SRC output ignores the stop |
| pcif_freerun | input | NPCIF | 1: PCIF output ignores the stop |
| oe | input | N | Per-output enable, 0 forces tristate |
| diff_pdtri | input | NCPU+NSRC | Per differential output: 1 = tristate in power-down |
| src_stop_tri | input | 1 | 1: stopped SRC outputs tristate, 0: driven low |
| gclk | output | N | Gated clocks |
| drive_en | output | N | 1: driver active, 0: tristate |
| vco_off | output | 1 | VCO shutdown request |
| fs_lat | output | FSW | Captured frequency-select straps |
| itp_lat | output | 1 | Captured debug-port strap |

## Verification
A change to `sw_stop_n`, `oe` or a free-run bit is registered on the next reference edge. It then reaches a gate after two rising edges and one falling edge of that output's own clock, which is under 70 ns for the slowest bench clock. `drive_en` follows its inputs one reference edge later. A pin change takes two synchronizer cycles before the sequencer reacts; after that, the clocks reopen only once the stabilization count has run out. The bench therefore waits 30 reference cycles after each stimulus before clearing its edge counters, and then judges activity over a 40-cycle window. The stabilization check samples its window well inside the 64-cycle count.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_PG, ST_STAB, ST_RUN, ST_DRAIN, ST_OFF
  } seq_state_t;

  typedef enum logic [2:0] {
    CL_CPU, CL_SRC, CL_PCI, CL_PCIF, CL_AUX
  } out_class_t;

  // position of an output decides its group
  function automatic out_class_t class_of(int idx, int ncpu, int nsrc, int npci, int npcif);
    if (idx < ncpu)                            return CL_CPU;
    else if (idx < ncpu + nsrc)                return CL_SRC;
    else if (idx < ncpu + nsrc + npci)         return CL_PCI;
    else if (idx < ncpu + nsrc + npci + npcif) return CL_PCIF;
    else                                       return CL_AUX;
  endfunction

  function automatic logic is_stoppable(out_class_t c);
    return (c == CL_SRC) || (c == CL_PCI) || (c == CL_PCIF);
  endfunction

  function automatic logic is_diff(out_class_t c);
    return (c == CL_CPU) || (c == CL_SRC);
  endfunction

  function automatic logic gate_want(out_class_t c, logic sys_run, logic oe,
                                     logic stop_n, logic free);
    return sys_run & oe & ~(is_stoppable(c) & ~stop_n & ~free);
  endfunction

  function automatic logic drive_want(out_class_t c, logic pd, logic oe, logic pdtri,
                                      logic stop_n, logic free, logic stop_tri);
    logic tri_pd, tri_stop;
    tri_pd   = is_diff(c) & pd & pdtri;
    tri_stop = (c == CL_SRC) & ~stop_n & ~free & stop_tri;
    return oe & ~tri_pd & ~tri_stop;
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= {W{RST_VAL}};
      q    <= {W{RST_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate (
  input  logic clk_i,
  input  logic rst_n,
  input  logic run_i,
  output logic en_o,
  output logic gclk_o
);
  logic run_s;
  logic en_q;

  clkstop_sync #(.W(1), .RST_VAL(1'b0)) u_sync (
    .clk  (clk_i),
    .rst_n(rst_n),
    .d    (run_i),
    .q    (run_s)
  );

  // enable only changes on the falling edge, so the clock is low then
  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= run_s;
  end

  assign en_o   = en_q;
  assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl import clkstop_pkg::*; #(
  parameter int FSW         = 3,
  parameter int STAB_CYCLES = 25000,
  parameter int GUARD       = 16
) (
  input  logic           ref_clk,
  input  logic           rst_n,
  input  logic           pin_hi,
  input  logic           all_closed,
  input  logic [FSW-1:0] fs_strap,
  input  logic           itp_strap,
  output logic           sys_run,
  output logic           vco_off,
  output logic [FSW-1:0] fs_lat,
  output logic           itp_lat
);
  localparam int MAXC = (STAB_CYCLES > GUARD) ? STAB_CYCLES : GUARD;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_t    st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          capture;
  logic          armed_q;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    capture = 1'b0;
    case (st)
      ST_WAIT_PG: if (!pin_hi) begin
        st_n    = ST_STAB;
        cnt_n   = CW'(STAB_CYCLES - 1);
        capture = 1'b1;
      end
      ST_STAB: begin
        if (pin_hi) begin
          st_n  = ST_DRAIN;
          cnt_n = CW'(GUARD - 1);
        end else if (cnt == '0) st_n = ST_RUN;
        else                    cnt_n = cnt - 1'b1;
      end
      ST_RUN: if (pin_hi) begin
        st_n  = ST_DRAIN;
        cnt_n = CW'(GUARD - 1);
      end
      ST_DRAIN: begin
        if (cnt != '0)      cnt_n = cnt - 1'b1;
        else if (all_closed) st_n = ST_OFF;
      end
      ST_OFF: if (!pin_hi) begin
        st_n  = ST_STAB;
        cnt_n = CW'(STAB_CYCLES - 1);
      end
      default: st_n = ST_WAIT_PG;
    endcase
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_WAIT_PG;
      cnt     <= '0;
      sys_run <= 1'b0;
      vco_off <= 1'b1;
      fs_lat  <= '0;
      itp_lat <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      sys_run <= (st_n == ST_RUN);
      vco_off <= (st_n == ST_WAIT_PG) || (st_n == ST_OFF);
      if (capture) begin
        fs_lat  <= fs_strap;
        itp_lat <= itp_strap;
        armed_q <= 1'b1;
      end
    end
  end

  // checker-side count of quiet cycles (VCO on, gates held)
  logic [CW:0] quiet_cnt;
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                            quiet_cnt <= '0;
    else if (vco_off)                      quiet_cnt <= '0;
    else if (!sys_run && quiet_cnt < (CW+1)'(MAXC)) quiet_cnt <= quiet_cnt + 1'b1;
  end

  // R3
  stab_wait_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(sys_run) |-> (quiet_cnt >= (CW+1)'(STAB_CYCLES - 1)));

  // R7
  vco_after_close_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(vco_off) |-> $past(all_closed));

  // R2
  strap_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (armed_q && $past(armed_q)) |-> ($stable(fs_lat) && $stable(itp_lat)));
endmodule

// File: rtl/clkstop_seq.sv
`timescale 1ns/1ps
module clkstop_seq import clkstop_pkg::*; #(
  parameter int NCPU        = 2,
  parameter int NSRC        = 2,
  parameter int NPCI        = 2,
  parameter int NPCIF       = 2,
  parameter int NAUX        = 2,
  parameter int FSW         = 3,
  parameter int STAB_CYCLES = 25000,
  parameter int GUARD       = 16
) (
  input  logic                                    ref_clk,
  input  logic                                    por_n,
  input  logic                                    pg_pd,
  input  logic [NCPU+NSRC+NPCI+NPCIF+NAUX-1:0]    gen_clk,
  input  logic [FSW-1:0]                          fs_strap,
  input  logic                                    itp_strap,
  input  logic                                    sw_stop_n,
  input  logic [NSRC-1:0]                         src_freerun,
  input  logic [NPCIF-1:0]                        pcif_freerun,
  input  logic [NCPU+NSRC+NPCI+NPCIF+NAUX-1:0]    oe,
  input  logic [NCPU+NSRC-1:0]                    diff_pdtri,
  input  logic                                    src_stop_tri,
  output logic [NCPU+NSRC+NPCI+NPCIF+NAUX-1:0]    gclk,
  output logic [NCPU+NSRC+NPCI+NPCIF+NAUX-1:0]    drive_en,
  output logic                                    vco_off,
  output logic [FSW-1:0]                          fs_lat,
  output logic                                    itp_lat
);
  localparam int N     = NCPU + NSRC + NPCI + NPCIF + NAUX;
  localparam int NDIFF = NCPU + NSRC;

  logic         pin_hi;
  logic         sys_run;
  logic [N-1:0] run_req;
  logic [N-1:0] gate_en;
  logic [N-1:0] gate_ack;
  logic         all_closed;

  clkstop_sync #(.W(1), .RST_VAL(1'b1)) u_pin_sync (
    .clk  (ref_clk),
    .rst_n(por_n),
    .d    (pg_pd),
    .q    (pin_hi)
  );

  clkstop_sync #(.W(N), .RST_VAL(1'b0)) u_ack_sync (
    .clk  (ref_clk),
    .rst_n(por_n),
    .d    (gate_en),
    .q    (gate_ack)
  );

  assign all_closed = ~|gate_ack;

  clkstop_ctrl #(.FSW(FSW), .STAB_CYCLES(STAB_CYCLES), .GUARD(GUARD)) u_ctrl (
    .ref_clk   (ref_clk),
    .rst_n     (por_n),
    .pin_hi    (pin_hi),
    .all_closed(all_closed),
    .fs_strap  (fs_strap),
    .itp_strap (itp_strap),
    .sys_run   (sys_run),
    .vco_off   (vco_off),
    .fs_lat    (fs_lat),
    .itp_lat   (itp_lat)
  );

  for (genvar i = 0; i < N; i++) begin : g_out
    localparam out_class_t CLS = class_of(i, NCPU, NSRC, NPCI, NPCIF);
    logic free_b;
    logic pdtri_b;

    if (CLS == CL_SRC) begin : g_fsrc
      assign free_b = src_freerun[i - NCPU];
    end else if (CLS == CL_PCIF) begin : g_fpcif
      assign free_b = pcif_freerun[i - NCPU - NSRC - NPCI];
    end else begin : g_fnone
      assign free_b = 1'b0;
    end

    if (i < NDIFF) begin : g_diff
      assign pdtri_b = diff_pdtri[i];
    end else begin : g_single
      assign pdtri_b = 1'b0;
    end

    // requests registered in the reference domain so the crossing sees no glitch
    always_ff @(posedge ref_clk or negedge por_n) begin
      if (!por_n) begin
        run_req[i]  <= 1'b0;
        drive_en[i] <= 1'b0;
      end else begin
        run_req[i]  <= gate_want(CLS, sys_run, oe[i], sw_stop_n, free_b);
        drive_en[i] <= drive_want(CLS, vco_off, oe[i], pdtri_b, sw_stop_n,
                                  free_b, src_stop_tri);
      end
    end

    clkstop_gate u_gate (
      .clk_i (gen_clk[i]),
      .rst_n (por_n),
      .run_i (run_req[i]),
      .en_o  (gate_en[i]),
      .gclk_o(gclk[i])
    );

    // R6
    oe_tristate_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
      !$past(oe[i]) |-> !drive_en[i]);

    if (i < NDIFF) begin : g_pdchk
      // R8
      pd_tristate_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
        ($past(vco_off) && $past(diff_pdtri[i])) |-> !drive_en[i]);
    end
  end
endmodule

// File: tb/clkstop_seq_bench.sv
`timescale 1ns/1ps
module clkstop_seq_bench;
  localparam int NCPU = 2, NSRC = 2, NPCI = 2, NPCIF = 2, NAUX = 2;
  localparam int N = NCPU + NSRC + NPCI + NPCIF + NAUX;
  localparam int NDIFF = NCPU + NSRC;
  localparam int FSW = 3, STAB = 64, GUARD = 16;

  logic             ref_clk = 1'b0;
  logic             por_n = 1'b0, pg_pd = 1'b1;
  logic [N-1:0]     gen_clk = '0;
  logic [FSW-1:0]   fs_strap = '0;
  logic             itp_strap = 1'b0, sw_stop_n = 1'b1, src_stop_tri = 1'b0;
  logic [NSRC-1:0]  src_freerun = '0;
  logic [NPCIF-1:0] pcif_freerun = '0;
  logic [N-1:0]     oe = '1;
  logic [NDIFF-1:0] diff_pdtri = '0;
  logic [N-1:0]     gclk, drive_en;
  logic             vco_off, itp_lat;
  logic [FSW-1:0]   fs_lat;

  int checks = 0, fails = 0;
  int unsigned tick = 0;
  int edges [N];
  int runts [N];
  realtime t_rise [N];
  logic [N-1:0] gclk_at_off = '1;

  always #2.5 ref_clk = ~ref_clk;

  // gen clock i has half period 3+i ns
  always #0.5 begin
    tick++;
    for (int i = 0; i < N; i++) gen_clk[i] = 1'((tick / (6 + 2 * i)) % 2);
  end

  clkstop_seq #(.NCPU(NCPU), .NSRC(NSRC), .NPCI(NPCI), .NPCIF(NPCIF), .NAUX(NAUX),
                .FSW(FSW), .STAB_CYCLES(STAB), .GUARD(GUARD)) u_clkstop_seq (
    .ref_clk(ref_clk), .por_n(por_n), .pg_pd(pg_pd), .gen_clk(gen_clk),
    .fs_strap(fs_strap), .itp_strap(itp_strap), .sw_stop_n(sw_stop_n),
    .src_freerun(src_freerun), .pcif_freerun(pcif_freerun), .oe(oe),
    .diff_pdtri(diff_pdtri), .src_stop_tri(src_stop_tri), .gclk(gclk),
    .drive_en(drive_en), .vco_off(vco_off), .fs_lat(fs_lat), .itp_lat(itp_lat));

  for (genvar i = 0; i < N; i++) begin : g_mon
    initial t_rise[i] = -1.0;
    always @(posedge gclk[i]) begin
      edges[i]++;
      t_rise[i] = $realtime;
    end
    always @(negedge gclk[i])
      if (t_rise[i] >= 0.0 && ($realtime - t_rise[i]) < (3.0 + i - 0.01)) runts[i]++;
  end

  always @(posedge vco_off) gclk_at_off = gclk;

  task automatic cyc(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic activity(output logic [N-1:0] act);
    for (int i = 0; i < N; i++) edges[i] = 0;
    cyc(40);
    for (int i = 0; i < N; i++) act[i] = (edges[i] > 0);
  endtask

  function automatic logic [N-1:0] exp_run(logic run, logic stop_n, logic [NSRC-1:0] sf,
                                           logic [NPCIF-1:0] pf, logic [N-1:0] en);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic stopped;
      stopped = 1'b0;
      if (i >= NCPU && i < NCPU + NSRC) stopped = !stop_n && !sf[i - NCPU];
      else if (i >= NCPU + NSRC && i < NCPU + NSRC + NPCI) stopped = !stop_n;
      else if (i >= NCPU + NSRC + NPCI && i < N - NAUX) stopped = !stop_n && !pf[i - NCPU - NSRC - NPCI];
      r[i] = run && en[i] && !stopped;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_drive(logic pd, logic stop_n, logic [NSRC-1:0] sf,
                                             logic [N-1:0] en, logic [NDIFF-1:0] pt, logic st);
    logic [N-1:0] d;
    for (int i = 0; i < N; i++) begin
      d[i] = en[i];
      if (i < NDIFF && pd && pt[i]) d[i] = 1'b0;
      if (i >= NCPU && i < NDIFF && !stop_n && !sf[i - NCPU] && st) d[i] = 1'b0;
    end
    return d;
  endfunction

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #500us;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [N-1:0] act;
    cyc(4);
    // R1 reset state
    check("R1 reset gclk", 32'(gclk), 0);
    check("R1 reset vco_off/drive", {31'(drive_en), vco_off}, 32'd1);
    check("R1 reset straps", {28'(fs_lat), itp_lat}, 0);
    por_n = 1'b1;
    fs_strap = 3'b101; itp_strap = 1'b1;
    cyc(10);
    activity(act);
    check("R1 no clocks before power good", 32'(act), 0);
    check("R1 vco off before power good", 32'(vco_off), 1);
    check("R2 no capture before power good", {28'(fs_lat), itp_lat}, 0);

    // power good: capture and stabilization
    pg_pd = 1'b0;
    cyc(6);
    fs_strap = 3'b010; itp_strap = 1'b0;
    check("R2 straps captured", {28'(fs_lat), itp_lat}, {28'd5, 1'b1});
    check("R3 vco on in wait", 32'(vco_off), 0);
    activity(act);
    check("R3 gates closed during wait", 32'(act), 0);
    cyc(STAB + 10);
    activity(act);
    check("R3 clocks after wait", 32'(act), 32'(exp_run(1, 1, '0, '0, '1)));

    // R4/R5/R6/R9 sweep
    for (int k = 0; k < 32; k++) begin
      logic s_n;
      logic [NSRC-1:0] sf;
      logic [NPCIF-1:0] pf;
      logic [N-1:0] en;
      logic st;
      s_n = k[4]; sf = 2'(k >> 2); pf = 2'(k); st = (k % 3 == 0);
      en = (k % 4 == 1) ? ~(N'(1) << (k % N)) : '1;
      sw_stop_n = s_n; src_freerun = sf; pcif_freerun = pf; oe = en; src_stop_tri = st;
      cyc(30);
      check("R4/R5/R6 sweep drive", 32'(drive_en), 32'(exp_drive(0, s_n, sf, en, '0, st)));
      activity(act);
      check("R4/R5/R6 sweep activity", 32'(act), 32'(exp_run(1, s_n, sf, pf, en)));
    end

    // R9 explicit
    sw_stop_n = 1'b0; src_freerun = 2'b01; oe = '1;
    src_stop_tri = 1'b1; cyc(5);
    check("R9 stopped src tristate", 32'(drive_en), 32'(exp_drive(0, 0, 2'b01, '1, '0, 1)));
    src_stop_tri = 1'b0; cyc(5);
    check("R9 stopped src driven", 32'(drive_en), 32'({N{1'b1}}));

    // power down
    sw_stop_n = 1'b1; src_freerun = '0; diff_pdtri = 4'b0101; oe = '1;
    fs_strap = 3'b111; itp_strap = 1'b0;
    cyc(30);
    gclk_at_off = '1;
    pg_pd = 1'b1;
    cyc(80);
    check("R7 vco off", 32'(vco_off), 1);
    check("R7 all low when vco off rose", 32'(gclk_at_off), 0);
    activity(act);
    check("R7 no clocks in power down", 32'(act), 0);
    check("R8 drive modes in power down", 32'(drive_en), 32'(exp_drive(1, 1, '0, '1, 4'b0101, 0)));

    // release
    pg_pd = 1'b0;
    cyc(8);
    check("R11 drive back on release", 32'(drive_en), 32'({N{1'b1}}));
    activity(act);
    check("R3/R11 gates closed after release", 32'(act), 0);
    cyc(STAB);
    activity(act);
    check("R3 clocks back after wait", 32'(act), 32'({N{1'b1}}));
    check("R2 straps kept after power down", {28'(fs_lat), itp_lat}, {28'd5, 1'b1});

    // R10 no runt pulses anywhere
    for (int i = 0; i < N; i++) check($sformatf("R10 runt count out %0d", i), 32'(runts[i]), 0);
    finish_up();
  end
endmodule